// File: doc/BRIEF.md
# Target-Cycle Timing Connector Queue

This block joins two modules of a cycle-level timing model. The model runs on a host that spends many host clocks on each simulated target cycle. A producer pushes entries through an enqueue handshake. A consumer looks at the oldest entry through a head view and removes it with a dequeue strobe. Each side raises a commit strobe once it has finished its work for the current target cycle. The queue keeps its own target-cycle count, and that count moves forward only after both sides have committed.

All delay, bandwidth and occupancy rules are counted in target cycles, not host clocks. Each target cycle accepts a limited number of entries and releases a limited number. An entry becomes visible at the head only after a minimum number of target cycles has passed since it was accepted. The number of entries held is capped. Because every slot is equivalent, a module that is in effect a wire gets all of its modelled latency from this queue's minimum delay. A model with distinct lanes uses one instance per lane.

Saturating event counters run beside the timing path without affecting it. A small trace memory starts recording accepted entries once a trigger arrives.

Top module: `tgt_conn_queue`

## Requirements
- R1: After reset, `tgt_cycle` is 0, `done` is 0, `first_valid` is 0, `enq_ready` is 1, and all three statistics and `trace_fill` are 0.
- R2: `tgt_cycle` increases by exactly one once both `prod_commit` and `cons_commit` have been seen since the last advance. The two strobes may arrive in either order or in the same clock. `done` is 1 in the host clock that directly follows the advancing clock. Otherwise it is 0.
- R3: An entry is accepted in a clock where `enq_valid` and `enq_ready` are both 1. At most IN_TP entries are accepted per target cycle. Once the quota is used, `enq_ready` stays 0 until the next advance. An acceptance in the advancing clock counts against the target cycle that is closing.
- R4: The queue never holds more than MAX_OUT entries. `enq_ready` is 0 while it holds MAX_OUT, even in a clock where a dequeue also happens.
- R5: Each entry is stamped with the `tgt_cycle` value of its accepting clock. `first_valid` is 1 only while the head entry's age (`tgt_cycle` minus stamp) is at least MIN_DLY target cycles.
- R6: At most OUT_TP entries are dequeued per target cycle. After that, `first_valid` is 0 until the next advance.
- R7: Entries leave in acceptance order. `first_data` shows the head entry's data while `first_valid` is 1.
- R8: A `deq` strobe while `first_valid` is 0 removes nothing and is not counted.
- R9: `stat_enq` counts accepted entries. `stat_deq` counts dequeued entries. `stat_stall` counts host clocks in which `enq_valid` is 1 and the input quota of R3 is used up. Each counter stops at its all-ones value.
- R10: Recording starts in the clock after `trace_trig` is first seen 1. From then on, each accepted entry is written at the next trace index as {stamp, data}, with the stamp in the upper TS_W bits. Recording stops when TRACE_DEPTH entries are held. `trace_fill` gives the number recorded, and `trace_data` shows the entry at `trace_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Producer offers an entry |
| enq_data | input | DATA_W | Producer entry payload |
| enq_ready | output | 1 | Entry would be accepted this clock |
| prod_commit | input | 1 | Producer finished current target cycle |
| first_valid | output | 1 | Head entry may be taken |
| first_data | output | DATA_W | Head entry payload |
| deq | input | 1 | Consumer removes the head entry |
| cons_commit | input | 1 | Consumer finished current target cycle |
| done | output | 1 | Queue closed a target cycle (one clock) |
| tgt_cycle | output | TS_W | Current target-cycle count |
| stat_enq | output | STAT_W | Saturating accepted-entry count |
| stat_deq | output | STAT_W | Saturating dequeued-entry count |
| stat_stall | output | STAT_W | Saturating quota-stall clock count |
| trace_trig | input | 1 | Arms trace recording |
| trace_idx | input | clog2(TRACE_DEPTH) | Trace read index |
| trace_data | output | TS_W+DATA_W | Trace entry {stamp, data} |
| trace_fill | output | clog2(TRACE_DEPTH+1) | Number of trace entries recorded |

## Verification
Two pairs of functions can land on the same host clock. The first pair is an enqueue and a dequeue: the stimulus table accepts a new entry in the clock that removes the head. It also offers an entry while the queue is full during a dequeue, and `enq_ready` must stay 0 there. The second pair is the two commit strobes: they arrive together in one clock, the expected `tgt_cycle` and `done` columns require a single-step advance, and a separate case lets the producer commit first. The expected head data, ready and valid are worked out for every row from the quotas, stamps and minimum delay.

// File: rtl/tcq_pkg.sv
package tcq_pkg;

  // True when used < lim (quota or capacity still open).
  function automatic logic under_limit(input logic [31:0] used, input logic [31:0] lim);
    return used < lim;
  endfunction

  // Modular age of a stamp against the current target cycle, compared with a minimum.
  function automatic logic aged_enough(input logic [31:0] now_c, input logic [31:0] stamp,
                                       input logic [31:0] min_gap, input int unsigned ts_bits);
    logic [31:0] gap;
    gap = now_c - stamp;
    if (ts_bits < 32) gap = gap & ((32'd1 << ts_bits) - 32'd1);
    return gap >= min_gap;
  endfunction

endpackage

// File: rtl/tcq_cycle_tracker.sv
module tcq_cycle_tracker #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prod_commit,
  input  logic            cons_commit,
  output logic            advance,
  output logic [TS_W-1:0] tc,
  output logic            done
);
  logic prod_seen, cons_seen;

  assign advance = (prod_seen | prod_commit) & (cons_seen | cons_commit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_seen <= 1'b0;
      cons_seen <= 1'b0;
      tc        <= '0;
      done      <= 1'b0;
    end else begin
      done <= advance;
      if (advance) begin
        prod_seen <= 1'b0;
        cons_seen <= 1'b0;
        tc        <= tc + TS_W'(1);
      end else begin
        prod_seen <= prod_seen | prod_commit;
        cons_seen <= cons_seen | cons_commit;
      end
    end
  end

  // R2
  tc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc != $past(tc)) |-> (tc == $past(tc) + TS_W'(1)));
  // R2
  done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tc != $past(tc)));
endmodule

// File: rtl/tcq_store.sv
module tcq_store #(
  parameter int DATA_W = 32,
  parameter int TS_W   = 16,
  parameter int DEPTH  = 8,
  parameter int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [TS_W-1:0]   push_ts,
  input  logic              pop,
  output logic [OCC_W-1:0]  occ,
  output logic [DATA_W-1:0] head_data,
  output logic [TS_W-1:0]   head_ts
);
  logic [DATA_W-1:0] d_q  [DEPTH];
  logic [TS_W-1:0]   ts_q [DEPTH];
  logic [DATA_W-1:0] up_d [DEPTH];
  logic [TS_W-1:0]   up_ts[DEPTH];
  logic [OCC_W-1:0]  wr_slot;

  // Shifted view: each slot sees its upper neighbour; the top slot holds.
  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (g == DEPTH - 1) begin : g_top
      assign up_d[g]  = d_q[g];
      assign up_ts[g] = ts_q[g];
    end else begin : g_mid
      assign up_d[g]  = d_q[g+1];
      assign up_ts[g] = ts_q[g+1];
    end
  end

  assign wr_slot   = pop ? occ - OCC_W'(1) : occ;
  assign head_data = d_q[0];
  assign head_ts   = ts_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        d_q[i]  <= '0;
        ts_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && (OCC_W'(i) == wr_slot)) begin
          d_q[i]  <= push_data;
          ts_q[i] <= push_ts;
        end else if (pop) begin
          d_q[i]  <= up_d[i];
          ts_q[i] <= up_ts[i];
        end
      end
      occ <= occ + OCC_W'(push) - OCC_W'(pop);
    end
  end

  // R4
  occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));
  // R8
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (occ != '0));
endmodule

// File: rtl/tcq_stats.sv
module tcq_stats #(
  parameter int STAT_W = 32,
  parameter int N_EV   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_EV-1:0]              ev,
  output logic [N_EV-1:0][STAT_W-1:0]  cnt
);
  for (genvar k = 0; k < N_EV; k++) begin : g_ctr
    logic at_top;
    assign at_top = &cnt[k];

    always_ff @(posedge clk) begin
      if (!rst_n)               cnt[k] <= '0;
      else if (ev[k] && !at_top) cnt[k] <= cnt[k] + STAT_W'(1);
    end

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&$past(cnt[k])) |-> (&cnt[k]));
  end
endmodule

// File: rtl/tcq_trace.sv
module tcq_trace #(
  parameter int TR_W  = 48,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            wr_en,
  input  logic [TR_W-1:0] wr_data,
  input  logic [AW-1:0]   rd_idx,
  output logic [TR_W-1:0] rd_data,
  output logic [FW-1:0]   fill
);
  logic [TR_W-1:0] mem [DEPTH];
  logic            armed;
  logic            capture;

  assign capture = armed && wr_en && (fill < FW'(DEPTH));
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      fill  <= '0;
    end else begin
      if (trig) armed <= 1'b1;
      if (capture) fill <= fill + FW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (capture) mem[fill[AW-1:0]] <= wr_data;
  end

  // R10
  trace_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));
  // R10
  trace_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (fill == '0));
endmodule

// File: rtl/tgt_conn_queue.sv
module tgt_conn_queue
  import tcq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int TS_W        = 16,
  parameter int IN_TP       = 2,
  parameter int OUT_TP      = 2,
  parameter int MIN_DLY     = 1,
  parameter int MAX_OUT     = 8,
  parameter int STAT_W      = 32,
  parameter int TRACE_DEPTH = 512,
  localparam int OCC_W      = $clog2(MAX_OUT + 1),
  localparam int IQ_W       = $clog2(IN_TP + 1),
  localparam int OQ_W       = $clog2(OUT_TP + 1),
  localparam int TR_AW      = $clog2(TRACE_DEPTH),
  localparam int TR_FW      = $clog2(TRACE_DEPTH + 1),
  localparam int TR_W       = TS_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [DATA_W-1:0] enq_data,
  output logic              enq_ready,
  input  logic              prod_commit,
  output logic              first_valid,
  output logic [DATA_W-1:0] first_data,
  input  logic              deq,
  input  logic              cons_commit,
  output logic              done,
  output logic [TS_W-1:0]   tgt_cycle,
  output logic [STAT_W-1:0] stat_enq,
  output logic [STAT_W-1:0] stat_deq,
  output logic [STAT_W-1:0] stat_stall,
  input  logic              trace_trig,
  input  logic [TR_AW-1:0]  trace_idx,
  output logic [TR_W-1:0]   trace_data,
  output logic [TR_FW-1:0]  trace_fill
);
  logic              advance;
  logic [OCC_W-1:0]  occ;
  logic [TS_W-1:0]   head_ts;
  logic [IQ_W-1:0]   in_used;
  logic [OQ_W-1:0]   out_used;
  logic              in_quota_ok, room_ok, head_ripe;
  logic              enq_fire, deq_fire, tp_stall;
  logic [2:0][STAT_W-1:0] stat_vec;

  tcq_cycle_tracker #(.TS_W(TS_W)) u_tracker (
    .clk(clk), .rst_n(rst_n), .prod_commit(prod_commit), .cons_commit(cons_commit),
    .advance(advance), .tc(tgt_cycle), .done(done)
  );

  assign in_quota_ok = under_limit(32'(in_used), 32'(IN_TP));
  assign room_ok     = under_limit(32'(occ), 32'(MAX_OUT));
  assign enq_ready   = in_quota_ok && room_ok;
  assign enq_fire    = enq_valid && enq_ready;
  assign tp_stall    = enq_valid && !in_quota_ok;

  assign head_ripe   = (occ != '0) &&
                       aged_enough(32'(tgt_cycle), 32'(head_ts), 32'(MIN_DLY), TS_W);
  assign first_valid = head_ripe && under_limit(32'(out_used), 32'(OUT_TP));
  assign deq_fire    = deq && first_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_used  <= '0;
      out_used <= '0;
    end else if (advance) begin
      in_used  <= '0;
      out_used <= '0;
    end else begin
      in_used  <= in_used + IQ_W'(enq_fire);
      out_used <= out_used + OQ_W'(deq_fire);
    end
  end

  tcq_store #(.DATA_W(DATA_W), .TS_W(TS_W), .DEPTH(MAX_OUT), .OCC_W(OCC_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(enq_fire), .push_data(enq_data), .push_ts(tgt_cycle),
    .pop(deq_fire), .occ(occ), .head_data(first_data), .head_ts(head_ts)
  );

  tcq_stats #(.STAT_W(STAT_W), .N_EV(3)) u_stats (
    .clk(clk), .rst_n(rst_n), .ev({tp_stall, deq_fire, enq_fire}), .cnt(stat_vec)
  );
  assign stat_enq   = stat_vec[0];
  assign stat_deq   = stat_vec[1];
  assign stat_stall = stat_vec[2];

  tcq_trace #(.TR_W(TR_W), .DEPTH(TRACE_DEPTH), .AW(TR_AW), .FW(TR_FW)) u_trace (
    .clk(clk), .rst_n(rst_n), .trig(trace_trig), .wr_en(enq_fire),
    .wr_data({tgt_cycle, enq_data}), .rd_idx(trace_idx), .rd_data(trace_data), .fill(trace_fill)
  );

  // R3
  in_quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_used <= IQ_W'(IN_TP));
  // R6
  out_quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_used <= OQ_W'(OUT_TP));
  // R4
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(MAX_OUT)) |-> !enq_ready);
  // R5
  stale_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_valid && MIN_DLY > 0) |-> (head_ts != tgt_cycle));
endmodule

// File: tb/tgt_conn_queue_bench.sv
module tgt_conn_queue_bench;
  localparam int DW = 8, TW = 8, SW = 6, TD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 0, prod_commit = 0, deq = 0, cons_commit = 0, trace_trig = 0;
  logic [DW-1:0] enq_data = '0;
  logic enq_ready, first_valid, done;
  logic [DW-1:0] first_data;
  logic [TW-1:0] tgt_cycle;
  logic [SW-1:0] stat_enq, stat_deq, stat_stall;
  logic [2:0] trace_idx = '0;
  logic [TW+DW-1:0] trace_data;
  logic [3:0] trace_fill;

  int checks = 0, errors = 0;

  tgt_conn_queue #(.DATA_W(DW), .TS_W(TW), .IN_TP(2), .OUT_TP(1), .MIN_DLY(2),
                   .MAX_OUT(4), .STAT_W(SW), .TRACE_DEPTH(TD)) u_tgt_conn_queue (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_data(enq_data), .enq_ready(enq_ready),
    .prod_commit(prod_commit), .first_valid(first_valid), .first_data(first_data), .deq(deq),
    .cons_commit(cons_commit), .done(done), .tgt_cycle(tgt_cycle), .stat_enq(stat_enq),
    .stat_deq(stat_deq), .stat_stall(stat_stall), .trace_trig(trace_trig), .trace_idx(trace_idx),
    .trace_data(trace_data), .trace_fill(trace_fill)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic en; logic [7:0] d; logic dq; logic pc; logic cc;
    logic rdy; logic fv; logic [7:0] fd; logic dn; logic [7:0] tc;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'd0},
    '{1'b1, 8'hA2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'd0},
    '{1'b1, 8'hA3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'd0},
    '{1'b1, 8'hA3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'd0},
    '{1'b1, 8'hA3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'd0},
    '{1'b1, 8'hA3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'd1},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'd1},
    '{1'b1, 8'hB1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA1, 1'b1, 8'd2},
    '{1'b1, 8'hB2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'd2},
    '{1'b1, 8'hB3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'd2},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'd2},
    '{1'b1, 8'hB3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA2, 1'b1, 8'd3},
    '{1'b1, 8'hB3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA2, 1'b0, 8'd3},
    '{1'b1, 8'hB3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'd3},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'd3},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA3, 1'b1, 8'd4},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'd4},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hB1, 1'b1, 8'd5},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'd5},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hB2, 1'b1, 8'd6},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'd6},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hB3, 1'b1, 8'd7},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'd7}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic idle_inputs();
    enq_valid = 0; enq_data = '0; deq = 0; prod_commit = 0; cons_commit = 0; trace_trig = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  logic [DW-1:0] rec_d  [16];
  logic [TW-1:0] rec_ts [16];
  int nrec;

  initial begin
    do_reset();
    #1;
    chk("R1 tgt_cycle", 32'(tgt_cycle), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 first_valid", 32'(first_valid), 0);
    chk("R1 enq_ready", 32'(enq_ready), 1);
    chk("R1 stat_enq", 32'(stat_enq), 0);
    chk("R1 stat_deq", 32'(stat_deq), 0);
    chk("R1 stat_stall", 32'(stat_stall), 0);
    chk("R1 trace_fill", 32'(trace_fill), 0);

    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      enq_valid = VEC[r].en; enq_data = VEC[r].d; deq = VEC[r].dq;
      prod_commit = VEC[r].pc; cons_commit = VEC[r].cc;
      #1;
      chk($sformatf("R3/R4 enq_ready row %0d", r), 32'(enq_ready), 32'(VEC[r].rdy));
      chk($sformatf("R5/R6 first_valid row %0d", r), 32'(first_valid), 32'(VEC[r].fv));
      if (VEC[r].fv)
        chk($sformatf("R7 first_data row %0d", r), 32'(first_data), 32'(VEC[r].fd));
      chk($sformatf("R2 done row %0d", r), 32'(done), 32'(VEC[r].dn));
      chk($sformatf("R2 tgt_cycle row %0d", r), 32'(tgt_cycle), 32'(VEC[r].tc));
    end
    @(negedge clk); idle_inputs(); #1;
    chk("R9 stat_enq after table", 32'(stat_enq), 6);
    chk("R9 stat_deq after table", 32'(stat_deq), 6);
    chk("R9 stat_stall after table", 32'(stat_stall), 4);
    chk("R10 no capture before trigger", 32'(trace_fill), 0);

    // R8: dequeue strobe on an empty queue
    @(negedge clk); deq = 1;
    @(negedge clk); deq = 0; #1;
    chk("R8 stat_deq unchanged", 32'(stat_deq), 6);
    chk("R8 first_valid still low", 32'(first_valid), 0);

    // R9: saturate the stall counter (2 accepted, then 68 stalled clocks)
    @(negedge clk); enq_valid = 1; enq_data = 8'h11;
    repeat (70) @(negedge clk);
    idle_inputs(); #1;
    chk("R9 stat_stall saturates", 32'(stat_stall), 63);
    chk("R9 stat_enq counts quota accepts", 32'(stat_enq), 8);

    // R10: trace capture after a trigger pulse
    do_reset();
    trace_trig = 1;
    @(negedge clk); trace_trig = 0;
    nrec = 0;
    for (int k = 0; k < 12; k++) begin
      enq_valid = 1; enq_data = 8'(8'h40 + k); prod_commit = 1; cons_commit = 1; deq = 1;
      #1;
      if (enq_ready && nrec < 16) begin
        rec_d[nrec] = enq_data; rec_ts[nrec] = tgt_cycle; nrec++;
      end
      @(negedge clk);
    end
    idle_inputs(); #1;
    chk("R10 accepted count", 32'(nrec), 12);
    chk("R10 trace_fill stops at depth", 32'(trace_fill), TD);
    for (int i = 0; i < TD; i++) begin
      trace_idx = 3'(i); #1;
      chk($sformatf("R10 trace entry %0d", i), 32'(trace_data), 32'({rec_ts[i], rec_d[i]}));
    end
    report();
  end
endmodule